// File: doc/BRIEF.md
# NAND Flash Bus Cycle Strobe Sequencer

This block runs one bus cycle at a time on an 8-bit asynchronous NAND flash device. An upstream master hands it a request that holds a cycle kind and a byte. The kinds are command latch, address latch, data write and data read. The block then drives the active-low chip enable, the command and address latch enables, the active-low write and read enables, and the bidirectional data bus. Every strobe edge sits at a programmable count of clock cycles from the start of the cycle.

The block does not derive flash addresses from any system address. Each address byte reaches the flash only when the master requests an address-latch cycle for it, and the master also decides the order of commands, addresses and data. The master may change the timing values between cycles, so each command or address sequence can run with its own timing.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the master holds its request until the current cycle has finished. When a cycle finishes, `done` pulses for one clock. A read cycle also presents the captured byte on `rd_byte`. The flash ready/busy pin is synchronised and brought out as a status bit.

Top module: `nand_strobe_seq`

## Requirements
- R1: `req_ready` is 1 only while the sequencer is idle, and it stays 0 from the edge that accepts a request until the cycle has finished. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1.
- R2: A command cycle (`req_kind` = 0) drives chip enable low over the CS window, which closes at the CS write-off time. It drives CLE high over the ADV window and write enable low over the WE window. ALE stays 0 and read enable stays 1.
- R3: An address cycle (`req_kind` = 1) uses the same chip-enable and write-enable windows as a command cycle. ALE, not CLE, follows the ADV window. CLE stays 0 and read enable stays 1.
- R4: A data write cycle (`req_kind` = 2) drives chip enable over the CS write window and write enable over the WE window. CLE and ALE stay 0 and read enable stays 1.
- R5: A data read cycle (`req_kind` = 3) drives chip enable over a window that closes at the separate CS read-off time. It drives read enable low over the OE window. Write enable stays 1, CLE and ALE stay 0, and `dq_oe` is 0.
- R6: Cycle counts start at 0 in the first clock after the accepting edge. A strobe is active in count n when on ≤ n < off. If off ≤ on, the strobe is never asserted in that cycle.
- R7: The cycle lasts `max(off times of its kind)` counts, and at least one count. For command and address cycles those off times are CS write-off, ADV write-off and WE-off. For write cycles they are CS write-off and WE-off. For read cycles they are CS read-off and OE-off. `done` is high for exactly the one clock after the last count, and all strobes are inactive in that clock.
- R8: In command, address and write cycles, `dq_oe` is 1 and `dq_out` equals the request byte for every count of the cycle.
- R9: In a read cycle, `rd_byte` takes the value of `dq_in` on the edge that ends count OE-off−1, which is where read enable deasserts. That value is present on `rd_byte` from `done` onwards.
- R10: A chip-select valid bit resets to 1 when `CS_INDEX` is 0. It is loaded from `csv_wr_val` on an edge with `csv_wr_en` = 1. While it is 0, no strobe is asserted and `dq_oe` is 0. An accepted request then gives `done` in the very next clock.
- R11: The timing inputs are sampled on the accepting edge. Changing them during a cycle does not affect that cycle, but the new values apply to the next cycle.
- R12: `flash_ready` is `rb_n` passed through two flip-flops, so a change shows after the second rising edge. It resets to 1, meaning the flash is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_byte | input | 8 | Byte to drive for command, address or write |
| t_cs_on | input | 4 | Chip enable assert count |
| t_cs_wr_off | input | 4 | Chip enable release count, write-type cycles |
| t_cs_rd_off | input | 4 | Chip enable release count, read cycles |
| t_adv_on | input | 4 | CLE/ALE assert count |
| t_adv_wr_off | input | 4 | CLE/ALE release count |
| t_we_on | input | 4 | Write enable assert count |
| t_we_off | input | 4 | Write enable release count |
| t_oe_on | input | 4 | Read enable assert count |
| t_oe_off | input | 4 | Read enable release count |
| csv_wr_en | input | 1 | Load the chip-select valid bit |
| csv_wr_val | input | 1 | Value to load |
| done | output | 1 | One-clock cycle completion pulse |
| rd_byte | output | 8 | Last captured read byte |
| rb_n | input | 1 | Flash ready/busy pin, low = busy |
| flash_ready | output | 1 | Synchronised ready status |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 8 | Data bus input value |

## Verification
The case that is hardest to reach from the ports is the read capture point. A fixed input byte cannot show which edge sampled it. The bench therefore changes `dq_in` to a new, count-tagged value in every clock of the read cycle, so the value that ends up in `rd_byte` identifies the count in which it was sampled. A second hard case is a timing change in the middle of a cycle. The bench rewrites every timing input one count after acceptance, checks the rest of the cycle against the values it had snapshotted, and then runs a further cycle to confirm that the new values take effect.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WRITE = 2'd2,
    K_READ  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_DONE = 2'd2
  } state_e;

  localparam int NUM_WIN = 4;
  localparam int W_CS  = 0;
  localparam int W_ADV = 1;
  localparam int W_WE  = 2;
  localparam int W_OE  = 3;
endpackage

// File: rtl/nsq_window.sv
module nsq_window #(
  parameter int TW = 4
) (
  input  logic          en,
  input  logic [TW-1:0] cnt,
  input  logic [TW-1:0] t_on,
  input  logic [TW-1:0] t_off,
  output logic          act
);
  // Active from the on count up to, not including, the off count.
  assign act = en && (cnt >= t_on) && (cnt < t_off);
endmodule

// File: rtl/nsq_sync.sv
module nsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nsq_pkg::*;
#(
  parameter int TW          = 4,
  parameter int DW          = 8,
  parameter int CS_INDEX    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_byte,
  input  logic [TW-1:0] t_cs_on,
  input  logic [TW-1:0] t_cs_wr_off,
  input  logic [TW-1:0] t_cs_rd_off,
  input  logic [TW-1:0] t_adv_on,
  input  logic [TW-1:0] t_adv_wr_off,
  input  logic [TW-1:0] t_we_on,
  input  logic [TW-1:0] t_we_off,
  input  logic [TW-1:0] t_oe_on,
  input  logic [TW-1:0] t_oe_off,
  input  logic          csv_wr_en,
  input  logic          csv_wr_val,
  output logic          done,
  output logic [DW-1:0] rd_byte,
  input  logic          rb_n,
  output logic          flash_ready,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  input  logic [DW-1:0] dq_in
);
  localparam logic CSV_RESET = (CS_INDEX == 0);

  function automatic logic [TW-1:0] tmax(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  state_e        state;
  kind_e         kind_q;
  logic [DW-1:0] byte_q;
  logic [TW-1:0] cnt;
  logic [TW-1:0] cs_on_q, cs_wr_q, cs_rd_q, adv_on_q, adv_off_q;
  logic [TW-1:0] we_on_q, we_off_q, oe_on_q, oe_off_q;
  logic          csv_q;
  logic [DW-1:0] rd_q;

  logic          run, is_rd, is_ca;
  logic [TW-1:0] end_cnt;
  logic          last;
  logic          cap;

  logic [TW-1:0] w_on  [NUM_WIN];
  logic [TW-1:0] w_off [NUM_WIN];
  logic          w_en  [NUM_WIN];
  logic          w_act [NUM_WIN];

  assign run   = (state == S_RUN) && csv_q;
  assign is_rd = (kind_q == K_READ);
  assign is_ca = (kind_q == K_CMD) || (kind_q == K_ADDR);

  always_comb begin
    if (is_rd) end_cnt = tmax(cs_rd_q, oe_off_q);
    else       end_cnt = tmax(tmax(cs_wr_q, we_off_q), is_ca ? adv_off_q : '0);
  end

  assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, end_cnt};

  // Window routing per cycle kind.
  always_comb begin
    w_on[W_CS]   = cs_on_q;
    w_off[W_CS]  = is_rd ? cs_rd_q : cs_wr_q;
    w_en[W_CS]   = run;
    w_on[W_ADV]  = adv_on_q;
    w_off[W_ADV] = adv_off_q;
    w_en[W_ADV]  = run && is_ca;
    w_on[W_WE]   = we_on_q;
    w_off[W_WE]  = we_off_q;
    w_en[W_WE]   = run && !is_rd;
    w_on[W_OE]   = oe_on_q;
    w_off[W_OE]  = oe_off_q;
    w_en[W_OE]   = run && is_rd;
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    nsq_window #(.TW(TW)) u_win (
      .en   (w_en[g]),
      .cnt  (cnt),
      .t_on (w_on[g]),
      .t_off(w_off[g]),
      .act  (w_act[g])
    );
  end

  assign cap = run && is_rd && (oe_on_q < oe_off_q) &&
               (({1'b0, cnt} + 1'b1) == {1'b0, oe_off_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csv_q <= CSV_RESET;
    else if (csv_wr_en) csv_q <= csv_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      kind_q    <= K_CMD;
      byte_q    <= '0;
      cnt       <= '0;
      cs_on_q   <= '0;
      cs_wr_q   <= '0;
      cs_rd_q   <= '0;
      adv_on_q  <= '0;
      adv_off_q <= '0;
      we_on_q   <= '0;
      we_off_q  <= '0;
      oe_on_q   <= '0;
      oe_off_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          kind_q    <= kind_e'(req_kind);
          byte_q    <= req_byte;
          cnt       <= '0;
          cs_on_q   <= t_cs_on;
          cs_wr_q   <= t_cs_wr_off;
          cs_rd_q   <= t_cs_rd_off;
          adv_on_q  <= t_adv_on;
          adv_off_q <= t_adv_wr_off;
          we_on_q   <= t_we_on;
          we_off_q  <= t_we_off;
          oe_on_q   <= t_oe_on;
          oe_off_q  <= t_oe_off;
          state     <= csv_q ? S_RUN : S_DONE;
        end
        S_RUN: begin
          if (last) state <= S_DONE;
          else      cnt   <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_q <= '0;
    else if (cap) rd_q <= dq_in;
  end

  nsq_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (rb_n),
    .q    (flash_ready)
  );

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign rd_byte   = rd_q;
  assign ce_n      = !w_act[W_CS];
  assign cle       = w_act[W_ADV] && (kind_q == K_CMD);
  assign ale       = w_act[W_ADV] && (kind_q == K_ADDR);
  assign we_n      = !w_act[W_WE];
  assign re_n      = !w_act[W_OE];
  assign dq_oe     = run && !is_rd;
  assign dq_out    = byte_q;
endmodule

// File: rtl/nsq_checker.sv
module nsq_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic ce_n,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic csv_q
);
  // R2
  latch_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));

  // R5
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));

  // R5
  bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> !dq_oe);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R1
  busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !req_ready);

  // R10
  csv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csv_q |-> (ce_n && we_n && re_n && !cle && !ale && !dq_oe));
endmodule

bind nand_strobe_seq nsq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .ce_n     (ce_n),
  .cle      (cle),
  .ale      (ale),
  .we_n     (we_n),
  .re_n     (re_n),
  .dq_oe    (dq_oe),
  .csv_q    (csv_q)
);

// File: tb/nand_strobe_seq_test.sv
module nand_strobe_seq_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic       req_ready;
  logic [1:0] req_kind = 0;
  logic [7:0] req_byte = 0;
  logic [3:0] t_cs_on = 0, t_cs_wr_off = 0, t_cs_rd_off = 0, t_adv_on = 0, t_adv_wr_off = 0;
  logic [3:0] t_we_on = 0, t_we_off = 0, t_oe_on = 0, t_oe_off = 0;
  logic       csv_wr_en = 0, csv_wr_val = 0;
  logic       done;
  logic [7:0] rd_byte;
  logic       rb_n = 1;
  logic       flash_ready;
  logic       ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0] dq_out;
  logic [7:0] dq_in = 0;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  nand_strobe_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_byte(req_byte),
    .t_cs_on(t_cs_on), .t_cs_wr_off(t_cs_wr_off), .t_cs_rd_off(t_cs_rd_off),
    .t_adv_on(t_adv_on), .t_adv_wr_off(t_adv_wr_off), .t_we_on(t_we_on),
    .t_we_off(t_we_off), .t_oe_on(t_oe_on), .t_oe_off(t_oe_off),
    .csv_wr_en(csv_wr_en), .csv_wr_val(csv_wr_val), .done(done), .rd_byte(rd_byte),
    .rb_n(rb_n), .flash_ready(flash_ready), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic bit win(input int k, input logic [3:0] on, input logic [3:0] off);
    return (k >= on) && (k < off);
  endfunction

  task automatic set_timing(input logic [3:0] cs_on, cs_wr, cs_rd, adv_on, adv_off,
                            we_on, we_off, oe_on, oe_off);
    t_cs_on = cs_on; t_cs_wr_off = cs_wr; t_cs_rd_off = cs_rd;
    t_adv_on = adv_on; t_adv_wr_off = adv_off; t_we_on = we_on; t_we_off = we_off;
    t_oe_on = oe_on; t_oe_off = oe_off;
  endtask

  // Runs one cycle and checks every count against windows computed from
  // the timing values present at acceptance. mutate rewrites timings at count 1.
  task automatic run_cycle(input logic [1:0] kind, input logic [7:0] b,
                           input string tag, input bit mutate);
    logic [3:0] cs_on, cs_off, adv_on, adv_off, we_on, we_off, oe_on, oe_off;
    int e, n;
    bit rd, ca;
    logic [5:0] exp_v, act_v;
    rd = (kind == 2'd3);
    ca = (kind <= 2'd1);
    cs_on = t_cs_on; cs_off = rd ? t_cs_rd_off : t_cs_wr_off;
    adv_on = t_adv_on; adv_off = t_adv_wr_off;
    we_on = t_we_on; we_off = t_we_off; oe_on = t_oe_on; oe_off = t_oe_off;
    if (rd) e = (t_cs_rd_off > t_oe_off) ? t_cs_rd_off : t_oe_off;
    else begin
      e = (t_cs_wr_off > t_we_off) ? t_cs_wr_off : t_we_off;
      if (ca && t_adv_wr_off > e) e = t_adv_wr_off;
    end
    n = (e == 0) ? 1 : e;
    @(negedge clk);
    check(req_ready == 1'b1, {"R1 ready idle ", tag}, req_ready, 1);
    req_valid = 1; req_kind = kind; req_byte = b;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 1'b0, {"R1 ready busy ", tag}, req_ready, 0);
    for (int k = 0; k < n; k++) begin
      if (rd) dq_in = 8'h40 + 8'(k);
      if (mutate && k == 1) set_timing(4'd0, 4'd1, 4'd1, 4'd0, 4'd1, 4'd0, 4'd1, 4'd0, 4'd1);
      exp_v[5] = !win(k, cs_on, cs_off);
      exp_v[4] = (kind == 2'd0) && win(k, adv_on, adv_off);
      exp_v[3] = (kind == 2'd1) && win(k, adv_on, adv_off);
      exp_v[2] = !(!rd && win(k, we_on, we_off));
      exp_v[1] = !(rd && win(k, oe_on, oe_off));
      exp_v[0] = !rd;
      act_v = {ce_n, cle, ale, we_n, re_n, dq_oe};
      check(act_v == exp_v, $sformatf("R2 R3 R4 R5 R6 R11 strobes %s count %0d", tag, k),
            act_v, exp_v);
      check(done == 1'b0, {"R7 no early done ", tag}, done, 0);
      if (!rd) check(dq_out == b, {"R8 bus byte ", tag}, dq_out, b);
      @(negedge clk);
    end
    check(done == 1'b1, {"R7 done pulse ", tag}, done, 1);
    act_v = {ce_n, cle, ale, we_n, re_n, dq_oe};
    check(act_v == 6'b100110, {"R7 idle in done ", tag}, act_v, 6'b100110);
    if (rd && oe_on < oe_off)
      check(rd_byte == 8'h40 + 8'(oe_off) - 8'd1, {"R9 read capture ", tag},
            rd_byte, 8'h40 + 8'(oe_off) - 8'd1);
  endtask

  task automatic t_reset();
    check({ce_n, cle, ale, we_n, re_n, dq_oe} == 6'b100110, "R7 reset pins",
          {ce_n, cle, ale, we_n, re_n, dq_oe}, 6'b100110);
    check(req_ready == 1 && done == 0, "R1 reset handshake", {req_ready, done}, 2'b10);
    check(flash_ready == 1, "R12 reset ready", flash_ready, 1);
  endtask

  task automatic t_command();
    set_timing(0, 6, 9, 1, 5, 2, 4, 0, 0);
    run_cycle(2'd0, 8'h70, "cmd", 0);
  endtask

  task automatic t_address();
    set_timing(0, 6, 9, 1, 7, 2, 4, 0, 0);
    run_cycle(2'd1, 8'h3C, "addr", 0);
  endtask

  task automatic t_write();
    // ADV off of 12 must not stretch a data write (R7).
    set_timing(0, 5, 9, 0, 12, 1, 3, 0, 0);
    run_cycle(2'd2, 8'hA5, "write", 0);
  endtask

  task automatic t_read();
    set_timing(0, 3, 7, 0, 12, 0, 9, 2, 6);
    run_cycle(2'd3, 8'h00, "read", 0);
  endtask

  task automatic t_empty_window();
    set_timing(1, 5, 0, 0, 3, 4, 4, 0, 0);
    run_cycle(2'd0, 8'h11, "we off eq on", 0);
    set_timing(0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_cycle(2'd2, 8'h22, "all zero", 0);
    set_timing(0, 0, 4, 0, 0, 0, 0, 5, 3);
    run_cycle(2'd3, 8'h00, "re off before on", 0);
  endtask

  task automatic t_reprogram();
    set_timing(1, 8, 0, 2, 6, 3, 7, 0, 0);
    run_cycle(2'd1, 8'h5A, "mid-cycle change", 1);
    run_cycle(2'd0, 8'hE1, "new timing", 0);
  endtask

  task automatic t_csv();
    @(negedge clk);
    csv_wr_en = 1; csv_wr_val = 0;
    @(negedge clk);
    csv_wr_en = 0;
    req_valid = 1; req_kind = 2'd0; req_byte = 8'hFF;
    set_timing(0, 6, 6, 0, 6, 0, 6, 0, 6);
    @(negedge clk);
    req_valid = 0;
    check(done == 1, "R10 immediate done", done, 1);
    check({ce_n, cle, ale, we_n, re_n, dq_oe} == 6'b100110, "R10 no strobes",
          {ce_n, cle, ale, we_n, re_n, dq_oe}, 6'b100110);
    @(negedge clk);
    check(req_ready == 1, "R10 back idle", req_ready, 1);
    csv_wr_en = 1; csv_wr_val = 1;
    @(negedge clk);
    csv_wr_en = 0;
    run_cycle(2'd2, 8'h99, "csv re-enabled R10", 0);
  endtask

  task automatic t_ready_busy();
    @(negedge clk);
    rb_n = 0;
    @(negedge clk);
    check(flash_ready == 1, "R12 one stage", flash_ready, 1);
    @(negedge clk);
    check(flash_ready == 0, "R12 busy seen", flash_ready, 0);
    rb_n = 1;
    @(negedge clk);
    @(negedge clk);
    check(flash_ready == 1, "R12 ready again", flash_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_command();
    t_address();
    t_write();
    t_read();
    t_empty_window();
    t_reprogram();
    t_csv();
    t_ready_busy();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_up();
  end
endmodule